// File: doc/BRIEF.md
# Register Rename Map with Free List

This block translates the logical register numbers of up to two decoded instructions per cycle into physical register numbers. Each instruction that writes a non-zero logical destination is given a brand-new physical register drawn from a circular free list. A physical register therefore carries exactly one value over its lifetime, and later readers depend only on physical numbers. For every renamed destination the block also returns the physical register that the logical one mapped to before. The caller keeps that tag until the instruction graduates and then hands it back through the graduation port, which pushes it onto the tail of the free list.

Renaming is all-or-nothing per cycle. When the free list cannot supply every destination that the pair asks for, `ready` drops and nothing in the group takes effect. The rename results are combinational from the current table state and are committed at the rising clock edge while `ready` is high. The second instruction of a pair sees the first one's fresh mapping, both for its sources and for its displaced destination. Logical register 0 is never renamed and always reads as physical register 0.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register n maps to physical register n for every n from 0 to 31. The free list holds physical registers 32 to 63 in ascending order, and `ready` is high.
- R2: While `ready` is high, each source output equals the current mapping of its logical source, and a source of logical 0 gives physical 0. In the second slot this holds unless R7 applies.
- R3: A slot allocates when its valid bit is 1, its has-destination bit is 1 and its destination is non-zero. Allocated tags are taken from the free-list head in first-in first-out order, slot 0 before slot 1. The new mapping is visible to sources from the next cycle on.
- R4: The old-tag output of an allocating slot is the mapping its destination held before this cycle's group.
- R5: A slot that does not allocate (no destination, or destination logical 0) outputs 0 as its new tag and as its old tag, and it consumes no free-list entry.
- R6: `ready` is low exactly when the free list holds fewer entries than the number of allocating slots. A graduation in the same cycle does not count toward that number. While `ready` is low, no mapping changes and no entry is consumed.
- R7: When slot 0 allocates, a slot-1 source equal to slot 0's destination receives slot 0's new tag. If both slots allocate the same destination, slot 1's old tag is slot 0's new tag, and the mapping that remains is slot 1's.
- R8: A graduation (valid with a physical tag) appends that tag to the free-list tail. It is handed out again once the entries ahead of it have been used.
- R9: The two tags allocated in one cycle differ from each other, and each differs from the old tag it displaces and from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in0_valid | input | 1 | Slot 0 instruction present |
| in0_has_dst | input | 1 | Slot 0 writes a destination |
| in0_src_a | input | 5 | Slot 0 first logical source |
| in0_src_b | input | 5 | Slot 0 second logical source |
| in0_dst | input | 5 | Slot 0 logical destination |
| in1_valid | input | 1 | Slot 1 instruction present |
| in1_has_dst | input | 1 | Slot 1 writes a destination |
| in1_src_a | input | 5 | Slot 1 first logical source |
| in1_src_b | input | 5 | Slot 1 second logical source |
| in1_dst | input | 5 | Slot 1 logical destination |
| grad_valid | input | 1 | A graduating instruction frees a physical register |
| grad_tag | input | 6 | Physical register being freed |
| ready | output | 1 | Group can be renamed this cycle; commit happens at the clock edge |
| out0_psrc_a | output | 6 | Slot 0 first physical source |
| out0_psrc_b | output | 6 | Slot 0 second physical source |
| out0_pdst | output | 6 | Slot 0 new physical destination |
| out0_pold | output | 6 | Slot 0 displaced physical destination |
| out1_psrc_a | output | 6 | Slot 1 first physical source |
| out1_psrc_b | output | 6 | Slot 1 second physical source |
| out1_pdst | output | 6 | Slot 1 new physical destination |
| out1_pold | output | 6 | Slot 1 displaced physical destination |

## Verification
On every cycle the assertions check these properties. Logical 0 reads and writes come out as physical 0. A freshly allocated tag is non-zero and differs both from the tag it displaces and from the other slot's tag. A slot-1 source that hits slot 0's destination picks up the new tag. A committed mapping is seen by a matching source one cycle later. Other behaviours need the bench's scenarios to show them, because they depend on history: the reset image of the table and the list, the exact first-in first-out order in which freed registers come back, the exact fill level at which `ready` falls (including a graduation arriving in the stalled cycle), and the absence of any update while stalled.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int LOG_REGS_DEF  = 32;
  localparam int PHYS_REGS_DEF = 64;
  localparam int SLOTS         = 2;
  localparam int MAP_READS     = 3 * SLOTS;
endpackage

// File: rtl/rename_rst_sync.sv
module rename_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int LOG_REGS = 32,
  parameter int PW       = 6,
  parameter int NRD      = 6,
  localparam int LW      = $clog2(LOG_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRD-1:0][LW-1:0]   rd_idx,
  output logic [NRD-1:0][PW-1:0]   rd_tag,
  input  logic [1:0]               wr_en,
  input  logic [1:0][LW-1:0]       wr_idx,
  input  logic [1:0][PW-1:0]       wr_tag
);
  logic [PW-1:0] map_q [LOG_REGS];

  // entry 0 is hard-wired: logical zero is never renamed
  assign map_q[0] = '0;

  for (genvar e = 1; e < LOG_REGS; e++) begin : g_entry
    localparam logic [PW-1:0] INIT_TAG = PW'(e);
    logic          hit0, hit1, ent_en;
    logic [PW-1:0] ent_d;

    always_comb begin
      hit0   = wr_en[0] && (wr_idx[0] == LW'(e));
      hit1   = wr_en[1] && (wr_idx[1] == LW'(e));
      ent_en = hit0 || hit1;
      // later slot of the group wins
      ent_d  = hit1 ? wr_tag[1] : wr_tag[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      map_q[e] <= INIT_TAG;
      else if (ent_en) map_q[e] <= ent_d;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_read
    assign rd_tag[r] = map_q[rd_idx[r]];
  end
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
  parameter int DEPTH    = 32,
  parameter int PW       = 6,
  parameter int BASE     = 32,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pop_n,
  input  logic          push,
  input  logic [PW-1:0] push_tag,
  output logic [PW-1:0] head_tag0,
  output logic [PW-1:0] head_tag1,
  output logic [CW-1:0] count,
  output logic          empty
);
  logic [PW-1:0] slot_q [DEPTH];
  logic [AW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] count_q, count_d;
  logic          ptr_en;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    else                     return p + 1'b1;
  endfunction

  always_comb begin
    unique case (pop_n)
      2'd1:    head_d = ptr_inc(head_q);
      2'd2:    head_d = ptr_inc(ptr_inc(head_q));
      default: head_d = head_q;
    endcase
    tail_d  = push ? ptr_inc(tail_q) : tail_q;
    count_d = count_q + CW'(push) - CW'(pop_n);
    ptr_en  = push || (pop_n != 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= CW'(DEPTH);
    end else if (ptr_en) begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    localparam logic [PW-1:0] INIT_TAG = PW'(BASE + k);
    logic slot_en;

    always_comb slot_en = push && (tail_q == AW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[k] <= INIT_TAG;
      else if (slot_en) slot_q[k] <= push_tag;
    end
  end

  assign head_tag0 = slot_q[head_q];
  assign head_tag1 = slot_q[ptr_inc(head_q)];
  assign count     = count_q;
  assign empty     = (count_q == '0);
endmodule

// File: rtl/rename_alloc_ctl.sv
module rename_alloc_ctl #(
  parameter int LW = 5,
  parameter int PW = 6,
  parameter int CW = 6
) (
  input  logic          v0,
  input  logic          has0,
  input  logic [LW-1:0] dst0,
  input  logic          v1,
  input  logic          has1,
  input  logic [LW-1:0] dst1,
  input  logic [LW-1:0] src1_a,
  input  logic [LW-1:0] src1_b,
  input  logic [PW-1:0] map_src1_a,
  input  logic [PW-1:0] map_src1_b,
  input  logic [PW-1:0] map_old0,
  input  logic [PW-1:0] map_old1,
  input  logic [PW-1:0] fl_tag0,
  input  logic [PW-1:0] fl_tag1,
  input  logic [CW-1:0] fl_count,
  input  logic          fl_empty,
  output logic          ready,
  output logic [1:0]    pop_n,
  output logic [1:0]    map_we,
  output logic [PW-1:0] pdst0,
  output logic [PW-1:0] pdst1,
  output logic [PW-1:0] pold0,
  output logic [PW-1:0] pold1,
  output logic [PW-1:0] psrc1_a,
  output logic [PW-1:0] psrc1_b
);
  logic       alloc0, alloc1;
  logic [1:0] need;

  always_comb begin
    alloc0 = v0 && has0 && (dst0 != '0);
    alloc1 = v1 && has1 && (dst1 != '0);
    need   = {1'b0, alloc0} + {1'b0, alloc1};
    ready  = fl_empty ? (need == 2'd0) : (32'(fl_count) >= 32'(need));

    pdst0 = alloc0 ? fl_tag0 : '0;
    pdst1 = alloc1 ? (alloc0 ? fl_tag1 : fl_tag0) : '0;
    pold0 = alloc0 ? map_old0 : '0;
    pold1 = alloc1 ? ((alloc0 && (dst0 == dst1)) ? pdst0 : map_old1) : '0;

    psrc1_a = (alloc0 && (src1_a == dst0)) ? pdst0 : map_src1_a;
    psrc1_b = (alloc0 && (src1_b == dst0)) ? pdst0 : map_src1_b;

    map_we = ready ? {alloc1, alloc0} : 2'b00;
    pop_n  = ready ? need : 2'd0;
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int  LOG_REGS  = rename_pkg::LOG_REGS_DEF,
  parameter int  PHYS_REGS = rename_pkg::PHYS_REGS_DEF,
  localparam int LW        = $clog2(LOG_REGS),
  localparam int PW        = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in0_valid,
  input  logic          in0_has_dst,
  input  logic [LW-1:0] in0_src_a,
  input  logic [LW-1:0] in0_src_b,
  input  logic [LW-1:0] in0_dst,
  input  logic          in1_valid,
  input  logic          in1_has_dst,
  input  logic [LW-1:0] in1_src_a,
  input  logic [LW-1:0] in1_src_b,
  input  logic [LW-1:0] in1_dst,
  input  logic          grad_valid,
  input  logic [PW-1:0] grad_tag,
  output logic          ready,
  output logic [PW-1:0] out0_psrc_a,
  output logic [PW-1:0] out0_psrc_b,
  output logic [PW-1:0] out0_pdst,
  output logic [PW-1:0] out0_pold,
  output logic [PW-1:0] out1_psrc_a,
  output logic [PW-1:0] out1_psrc_b,
  output logic [PW-1:0] out1_pdst,
  output logic [PW-1:0] out1_pold
);
  localparam int NRD      = rename_pkg::MAP_READS;
  localparam int FL_DEPTH = PHYS_REGS - LOG_REGS;
  localparam int CW       = $clog2(FL_DEPTH + 1);

  logic                   rst_sync_n;
  logic [NRD-1:0][LW-1:0] rd_idx;
  logic [NRD-1:0][PW-1:0] rd_tag;
  logic [1:0]             map_we;
  logic [1:0][LW-1:0]     map_widx;
  logic [1:0][PW-1:0]     map_wtag;
  logic [1:0]             pop_n;
  logic [PW-1:0]          fl_tag0, fl_tag1;
  logic [CW-1:0]          fl_count;
  logic                   fl_empty;

  rename_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // read port order: s0a, s0b, s1a, s1b, d0, d1
  assign rd_idx = {in1_dst, in0_dst, in1_src_b, in1_src_a, in0_src_b, in0_src_a};

  rename_map_table #(
    .LOG_REGS (LOG_REGS),
    .PW       (PW),
    .NRD      (NRD)
  ) u_map (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rd_idx (rd_idx),
    .rd_tag (rd_tag),
    .wr_en  (map_we),
    .wr_idx (map_widx),
    .wr_tag (map_wtag)
  );

  rename_free_list #(
    .DEPTH (FL_DEPTH),
    .PW    (PW),
    .BASE  (LOG_REGS)
  ) u_free (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pop_n     (pop_n),
    .push      (grad_valid),
    .push_tag  (grad_tag),
    .head_tag0 (fl_tag0),
    .head_tag1 (fl_tag1),
    .count     (fl_count),
    .empty     (fl_empty)
  );

  rename_alloc_ctl #(
    .LW (LW),
    .PW (PW),
    .CW (CW)
  ) u_ctl (
    .v0         (in0_valid),
    .has0       (in0_has_dst),
    .dst0       (in0_dst),
    .v1         (in1_valid),
    .has1       (in1_has_dst),
    .dst1       (in1_dst),
    .src1_a     (in1_src_a),
    .src1_b     (in1_src_b),
    .map_src1_a (rd_tag[2]),
    .map_src1_b (rd_tag[3]),
    .map_old0   (rd_tag[4]),
    .map_old1   (rd_tag[5]),
    .fl_tag0    (fl_tag0),
    .fl_tag1    (fl_tag1),
    .fl_count   (fl_count),
    .fl_empty   (fl_empty),
    .ready      (ready),
    .pop_n      (pop_n),
    .map_we     (map_we),
    .pdst0      (out0_pdst),
    .pdst1      (out1_pdst),
    .pold0      (out0_pold),
    .pold1      (out1_pold),
    .psrc1_a    (out1_psrc_a),
    .psrc1_b    (out1_psrc_b)
  );

  assign map_widx    = {in1_dst, in0_dst};
  assign map_wtag    = {out1_pdst, out0_pdst};
  assign out0_psrc_a = rd_tag[0];
  assign out0_psrc_b = rd_tag[1];
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int LW = 5,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in0_valid,
  input logic          in0_has_dst,
  input logic [LW-1:0] in0_src_a,
  input logic [LW-1:0] in0_dst,
  input logic          in1_valid,
  input logic          in1_has_dst,
  input logic [LW-1:0] in1_src_a,
  input logic [LW-1:0] in1_dst,
  input logic          ready,
  input logic [PW-1:0] out0_psrc_a,
  input logic [PW-1:0] out0_pdst,
  input logic [PW-1:0] out0_pold,
  input logic [PW-1:0] out1_psrc_a,
  input logic [PW-1:0] out1_pdst
);
  logic a0, a1;
  assign a0 = in0_valid && in0_has_dst && (in0_dst != '0);
  assign a1 = in1_valid && in1_has_dst && (in1_dst != '0);

  assert_zero_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in0_src_a == '0) |-> (out0_psrc_a == '0));

  assert_zero_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in0_valid && !a0) |-> (out0_pdst == '0 && out0_pold == '0));

  assert_fresh_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && a0) |-> (out0_pdst != '0 && out0_pdst != out0_pold));

  assert_pair_distinct_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && a0 && a1) |-> (out0_pdst != out1_pdst));

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && a0 && in1_valid && in1_src_a == in0_dst) |-> (out1_psrc_a == out0_pdst));

  assert_map_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ready && a0 && !(a1 && in1_dst == in0_dst))
     && in0_src_a == $past(in0_dst))
    |-> (out0_psrc_a == $past(out0_pdst)));
endmodule

bind rename_unit rename_unit_chk #(.LW(LW), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in0_valid   (in0_valid),
  .in0_has_dst (in0_has_dst),
  .in0_src_a   (in0_src_a),
  .in0_dst     (in0_dst),
  .in1_valid   (in1_valid),
  .in1_has_dst (in1_has_dst),
  .in1_src_a   (in1_src_a),
  .in1_dst     (in1_dst),
  .ready       (ready),
  .out0_psrc_a (out0_psrc_a),
  .out0_pdst   (out0_pdst),
  .out0_pold   (out0_pold),
  .out1_psrc_a (out1_psrc_a),
  .out1_pdst   (out1_pdst)
);

// File: tb/rename_unit_bench.sv
`timescale 1ns/1ps
module rename_unit_bench;
  localparam int NLOG = 32;
  localparam int FLD  = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in0_valid, in0_has_dst, in1_valid, in1_has_dst, grad_valid;
  logic [4:0] in0_src_a, in0_src_b, in0_dst, in1_src_a, in1_src_b, in1_dst;
  logic [5:0] grad_tag;
  logic       ready;
  logic [5:0] out0_psrc_a, out0_psrc_b, out0_pdst, out0_pold;
  logic [5:0] out1_psrc_a, out1_psrc_b, out1_pdst, out1_pold;

  always #2.5 clk = ~clk;

  rename_unit u_rename_unit (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(in0_valid), .in0_has_dst(in0_has_dst),
    .in0_src_a(in0_src_a), .in0_src_b(in0_src_b), .in0_dst(in0_dst),
    .in1_valid(in1_valid), .in1_has_dst(in1_has_dst),
    .in1_src_a(in1_src_a), .in1_src_b(in1_src_b), .in1_dst(in1_dst),
    .grad_valid(grad_valid), .grad_tag(grad_tag), .ready(ready),
    .out0_psrc_a(out0_psrc_a), .out0_psrc_b(out0_psrc_b),
    .out0_pdst(out0_pdst), .out0_pold(out0_pold),
    .out1_psrc_a(out1_psrc_a), .out1_psrc_b(out1_psrc_b),
    .out1_pdst(out1_pdst), .out1_pold(out1_pold)
  );

  // bench model of table, free list and pending old tags
  int m_map [NLOG];
  int m_fl  [FLD];
  int fh, ft, fcnt;
  int pend [64];
  int ph, pt, pcnt;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int last_grad;
  logic [31:0] lf = 32'h1234_5678;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic step(input bit v0, input bit h0, input int s0a, input int s0b, input int d0,
                      input bit v1, input bit h1, input int s1a, input int s1b, input int d1,
                      input bit gv);
    bit a0, a1, er;
    int need, pd0, pd1, po0, po1, ps1a, ps1b;
    @(negedge clk);
    in0_valid = v0; in0_has_dst = h0;
    in0_src_a = 5'(s0a); in0_src_b = 5'(s0b); in0_dst = 5'(d0);
    in1_valid = v1; in1_has_dst = h1;
    in1_src_a = 5'(s1a); in1_src_b = 5'(s1b); in1_dst = 5'(d1);
    grad_valid = gv && (pcnt > 0);
    grad_tag   = 6'(grad_valid ? pend[ph] : 0);
    #1;
    a0   = v0 && h0 && (d0 != 0);
    a1   = v1 && h1 && (d1 != 0);
    need = int'(a0) + int'(a1);
    er   = (fcnt >= need);
    pd0  = a0 ? m_fl[fh] : 0;
    pd1  = a1 ? (a0 ? m_fl[(fh + 1) % FLD] : m_fl[fh]) : 0;
    po0  = a0 ? m_map[d0] : 0;
    po1  = a1 ? ((a0 && d0 == d1) ? pd0 : m_map[d1]) : 0;
    ps1a = (a0 && s1a == d0) ? pd0 : m_map[s1a];
    ps1b = (a0 && s1b == d0) ? pd0 : m_map[s1b];
    chk("R6 ready", int'(ready), int'(er));
    if (v0) begin
      chk("R2 slot0 src a", int'(out0_psrc_a), m_map[s0a]);
      chk("R2 slot0 src b", int'(out0_psrc_b), m_map[s0b]);
      chk(a0 ? "R3 slot0 new tag" : "R5 slot0 new tag", int'(out0_pdst), pd0);
      chk(a0 ? "R4 slot0 old tag" : "R5 slot0 old tag", int'(out0_pold), po0);
    end
    if (v1) begin
      chk((a0 && s1a == d0) ? "R7 slot1 src a" : "R2 slot1 src a", int'(out1_psrc_a), ps1a);
      chk((a0 && s1b == d0) ? "R7 slot1 src b" : "R2 slot1 src b", int'(out1_psrc_b), ps1b);
      chk(a1 ? "R3 slot1 new tag" : "R5 slot1 new tag", int'(out1_pdst), pd1);
      chk((a0 && a1 && d0 == d1) ? "R7 slot1 old tag" : (a1 ? "R4 slot1 old tag" : "R5 slot1 old tag"),
          int'(out1_pold), po1);
    end
    if (er && a0 && a1) chk("R9 pair tags differ", int'(out0_pdst != out1_pdst), 1);
    // state update at the coming edge
    if (grad_valid) begin
      last_grad = pend[ph];
      ph = (ph + 1) % 64; pcnt--;
    end
    if (er) begin
      if (a0) begin m_map[d0] = pd0; pend[pt] = po0; pt = (pt + 1) % 64; pcnt++; end
      if (a1) begin m_map[d1] = pd1; pend[pt] = po1; pt = (pt + 1) % 64; pcnt++; end
      fh = (fh + need) % FLD; fcnt -= need;
    end
    if (grad_valid) begin
      m_fl[ft] = last_grad; ft = (ft + 1) % FLD; fcnt++;
    end
  endtask

  task automatic idle_grad();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {in0_valid, in0_has_dst, in1_valid, in1_has_dst, grad_valid} = '0;
    {in0_src_a, in0_src_b, in0_dst, in1_src_a, in1_src_b, in1_dst} = '0;
    grad_tag = '0;
    for (int i = 0; i < NLOG; i++) m_map[i] = i;
    for (int k = 0; k < FLD; k++) m_fl[k] = NLOG + k;
    fh = 0; ft = 0; fcnt = FLD; ph = 0; pt = 0; pcnt = 0; last_grad = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: identity map after reset
    for (int r = 0; r < NLOG; r++) begin
      step(1, 0, r, NLOG - 1 - r, 0, 1, 0, r, 0, 0, 0);
      chk("R1 reset map", int'(out0_psrc_a), r);
      chk("R1 reset map b", int'(out0_psrc_b), NLOG - 1 - r);
    end
    // R1: full list, ascending order
    step(1, 1, 1, 2, 1, 1, 1, 1, 2, 2, 0);
    chk("R1 ready full", int'(ready), 1);
    chk("R1 first tag", int'(out0_pdst), 32);
    chk("R1 second tag", int'(out1_pdst), 33);
    for (int r = 3; r < NLOG; r++) step(1, 1, r, 0, r, 0, 0, 0, 0, 0, 0);
    // one entry left, two requested
    step(1, 1, 0, 0, 4, 1, 1, 0, 0, 5, 0);
    chk("R6 stall on shortfall", int'(ready), 0);
    step(1, 0, 4, 5, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 no update while stalled", int'(out0_psrc_a), 35);
    chk("R6 no update while stalled b", int'(out0_psrc_b), 36);
    step(1, 1, 0, 0, 7, 0, 0, 0, 0, 0, 0);
    chk("R3 last list entry", int'(out0_pdst), 63);
    step(1, 1, 0, 0, 8, 0, 0, 0, 0, 0, 0);
    chk("R6 empty list stalls", int'(ready), 0);
    step(1, 1, 3, 0, 0, 1, 0, 3, 0, 0, 0);
    chk("R5 zero dest needs no entry", int'(ready), 1);
    chk("R5 zero dest tag", int'(out0_pdst), 0);
    // graduation in the same cycle does not relieve the stall
    step(1, 1, 0, 0, 9, 0, 0, 0, 0, 0, 1);
    chk("R6 same-cycle graduation ignored", int'(ready), 0);
    step(1, 1, 0, 0, 9, 0, 0, 0, 0, 0, 0);
    chk("R8 freed tag reused", int'(out0_pdst), last_grad);
    chk("R8 freed tag value", int'(out0_pdst), 1);

    // R7: pair sweep over destinations
    for (int d0 = 0; d0 < NLOG; d0++) begin
      for (int k = 0; k < 3; k++) begin
        int d1;
        d1 = (k == 0) ? d0 : ((k == 1) ? (d0 + 1) % NLOG : 0);
        while (fcnt < 2 && pcnt > 0) idle_grad();
        step(1, 1, d1, d0, d0, 1, 1, d0, d1, d1, 1);
      end
    end

    // mixed traffic, graduation rate alternating to drain and refill
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r1, r2;
      bit gv;
      lf = rnd(lf); r1 = lf;
      lf = rnd(lf); r2 = lf;
      gv = ((c / 400) % 2 == 0) ? (r2[30] & r2[31]) : (r2[30] | r2[31]);
      step(r1[0] | r1[1], r1[2] | r1[3], int'(r1[14:10]), int'(r1[19:15]),
           r1[4] ? int'(r1[9:5]) : int'(r1[6:5]),
           r2[0] | r2[1], r2[2] | r2[3],
           r1[20] ? (r1[4] ? int'(r1[9:5]) : int'(r1[6:5])) : int'(r1[25:21]),
           int'(r2[14:10]), r2[4] ? int'(r2[9:5]) : int'(r2[6:5]), gv);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule